// File: doc/BRIEF.md
# I2C Serial Clock Generator

This block produces the serial clock of an I2C controller from its functional clock. A programmable prescaler divides the input clock by `prescale + 1`, giving a slower module tick. Each half of the serial clock is then timed in module ticks. The low half lasts `low_len + d` ticks and the high half lasts `high_len + d` ticks. The fixed extra count `d` is set by the prescaler value: 7 for a prescale of 0, 6 for a prescale of 1, and 5 for any larger prescale. Because of this extra count, the period is not simply the sum of the two programmed lengths.

Software loads the three settings while the controller is held in reset, which is shown here by `enable` being low. It then raises `enable`. The block copies the settings in the cycle it sees `enable` high while idle, so later changes to the setting inputs cannot disturb a running clock. The first half-period after start is always the low one. While `enable` is low, the clock rests high.

The control is a three-state machine. IDLE is the reset and disabled state, LOW is the low half-period and HIGH is the high half-period. Its transitions are:
- start: IDLE to LOW, when `enable` is high.
- low_done: LOW to HIGH, on the last input cycle of the low half.
- high_done: HIGH to LOW, on the last input cycle of the high half.
- halt: any state to IDLE, when `enable` is low.

Top module: `sclgen_top`

## Requirements
- R1: While `enable` is low, and out of reset, `scl` is 1 and `phase` is 0 (IDLE) from the next cycle onward.
- R2: In the cycle after `enable` is first seen high in IDLE, `phase` becomes 1 (LOW) and `scl` becomes 0.
- R3: The low half-period lasts exactly (prescale+1)×(low_len+d) input clock cycles.
- R4: The high half-period lasts exactly (prescale+1)×(high_len+d) input clock cycles, and `phase` is 2 (HIGH) during it.
- R5: The extra count d is 7 when prescale is 0, 6 when prescale is 1, and 5 when prescale is 2 or more.
- R6: The low and high half-periods alternate, so the full period is (prescale+1)×(low_len+high_len+2d) cycles.
- R7: The settings are captured at start. Changing `prescale`, `low_len` or `high_len` while enabled has no effect on the half-period lengths.
- R8: Dropping `enable` returns the block to IDLE with `scl` high in the next cycle, whatever phase it was in.
- R9: The phase code is 0 for IDLE, 1 for LOW and 2 for HIGH, and `scl` is 0 exactly when the code is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input (functional) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | High to run; low holds the generator idle |
| prescale | input | 16 | Prescaler divide value minus one |
| low_len | input | 16 | Programmed low half length in module ticks |
| high_len | input | 16 | Programmed high half length in module ticks |
| scl | output | 1 | Generated serial clock |
| phase | output | 2 | Current phase: 0 IDLE, 1 LOW, 2 HIGH |

## Verification
The length checks assume the setting inputs seen in the start cycle are the ones that define the following half-periods. They also assume each half completes before `enable` falls, because a half cut short by halt is never compared. The stimulus raises `enable` only with settings already stable, and lets at least one low and one high half finish before dropping it. Prescale and lengths are kept small, so every d branch and many length pairs fit in a short run. Mid-run disturbance of the settings tests capture at start, without ever breaking the stable-at-start condition.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    // Fixed latency added to each half, selected by the prescale value
    function automatic logic [2:0] extra_ticks(input logic [31:0] pre);
        logic [2:0] r;
        if (pre == 32'd0)      r = 3'd7;
        else if (pre == 32'd1) r = 3'd6;
        else                   r = 3'd5;
        return r;
    endfunction

endpackage

// File: rtl/sclgen_presc.sv
module sclgen_presc #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);
    logic [PSC_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sclgen_halfcnt.sv
module sclgen_halfcnt #(
    parameter int TGT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [TGT_W-1:0] target,
    output logic             done
);
    logic [TGT_W-1:0] ticks;

    assign done = tick && (ticks == target - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ticks <= '0;
        end else if (!run || done) begin
            ticks <= '0;
        end else if (tick) begin
            ticks <= ticks + 1'b1;
        end
    end
endmodule

// File: rtl/sclgen_fsm.sv
module sclgen_fsm
    import sclgen_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   enable,
    input  logic   half_done,
    output phase_e state,
    output logic   load,
    output logic   run,
    output logic   scl
);
    phase_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            PH_IDLE: if (enable) nxt = PH_LOW;
            PH_LOW:  if (!enable) nxt = PH_IDLE;
                     else if (half_done) nxt = PH_HIGH;
            PH_HIGH: if (!enable) nxt = PH_IDLE;
                     else if (half_done) nxt = PH_LOW;
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        load = (state == PH_IDLE) && enable;
        run  = (state != PH_IDLE) && enable;
        scl  = (state != PH_LOW);
    end
endmodule

// File: rtl/sclgen_top.sv
module sclgen_top
    import sclgen_pkg::*;
#(
    parameter int PSC_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PSC_W-1:0] prescale,
    input  logic [CNT_W-1:0] low_len,
    input  logic [CNT_W-1:0] high_len,
    output logic             scl,
    output logic [1:0]       phase
);
    localparam int TGT_W = CNT_W + 1;

    phase_e           state;
    logic             load, run, tick, half_done;
    logic [PSC_W-1:0] psc_q;
    logic [CNT_W-1:0] low_q, high_q;
    logic [2:0]       extra_q;
    logic [TGT_W-1:0] target;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q   <= '0;
            low_q   <= '0;
            high_q  <= '0;
            extra_q <= 3'd7;
        end else if (load) begin
            psc_q   <= prescale;
            low_q   <= low_len;
            high_q  <= high_len;
            extra_q <= extra_ticks(32'(prescale));
        end
    end

    always_comb begin
        if (state == PH_HIGH) target = TGT_W'(high_q) + TGT_W'(extra_q);
        else                  target = TGT_W'(low_q) + TGT_W'(extra_q);
    end

    sclgen_presc #(.PSC_W(PSC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .div(psc_q), .tick(tick)
    );

    sclgen_halfcnt #(.TGT_W(TGT_W)) u_half (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .target(target), .done(half_done)
    );

    sclgen_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .half_done(half_done),
        .state(state), .load(load), .run(run), .scl(scl)
    );

    assign phase = state;
endmodule

// File: rtl/sclgen_chk.sv
module sclgen_chk #(
    parameter int PSC_W = 16,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [PSC_W-1:0] prescale,
    input logic [CNT_W-1:0] low_len,
    input logic [CNT_W-1:0] high_len,
    input logic             scl,
    input logic [1:0]       phase
);
    logic [1:0]  prev_ph;
    logic [35:0] run_len, exp_low, exp_high;

    function automatic logic [35:0] half_cycles(input logic [PSC_W-1:0] p,
                                                input logic [CNT_W-1:0] n);
        logic [35:0] dd;
        dd = (p == 0) ? 36'd7 : ((p == 1) ? 36'd6 : 36'd5);
        return (36'(p) + 36'd1) * (36'(n) + dd);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_ph  <= 2'd0;
            run_len  <= '0;
            exp_low  <= '0;
            exp_high <= '0;
        end else begin
            prev_ph <= phase;
            run_len <= (phase == prev_ph) ? run_len + 1'b1 : 36'd1;
            if (phase == 2'd0 && enable) begin
                exp_low  <= half_cycles(prescale, low_len);
                exp_high <= half_cycles(prescale, high_len);
            end
        end
    end

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl && phase == 2'd0));

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0 && enable) |=> (phase == 2'd1 && !scl));

    // R3
    low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2 && prev_ph == 2'd1) |-> (run_len == exp_low));

    // R4
    high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1 && prev_ph == 2'd2) |-> (run_len == exp_high));

    // R9
    scl_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl == (phase != 2'd1)) && (phase != 2'd3));

    // R6
    alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && phase == 2'd1) |=> (phase != 2'd0));
endmodule

bind sclgen_top sclgen_chk #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .prescale(prescale),
    .low_len(low_len), .high_len(high_len), .scl(scl), .phase(phase)
);

// File: tb/test_sclgen_top.sv
module test_sclgen_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] prescale = '0, low_len = '0, high_len = '0;
    logic        scl;
    logic [1:0]  phase;
    int errors = 0, checks = 0;
    int unsigned seed_v;

    always #2 clk = ~clk;

    sclgen_top i_sclgen_top (
        .clk(clk), .rst_n(rst_n), .enable(enable), .prescale(prescale),
        .low_len(low_len), .high_len(high_len), .scl(scl), .phase(phase)
    );

    function automatic int dval(input int p);
        return (p == 0) ? 7 : ((p == 1) ? 6 : 5);
    endfunction

    function automatic int half_exp(input int p, input int n);
        return (p + 1) * (n + dval(p));
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic count_while(input logic lvl, output int n);
        n = 0;
        while (scl == lvl && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Start with settings, measure low, high, low; optionally disturb settings mid-run
    task automatic run_case(input int p, input int l, input int h, input bit disturb);
        int nl, nh, nl2;
        @(negedge clk);
        prescale = 16'(p); low_len = 16'(l); high_len = 16'(h);
        enable = 1'b1;
        @(negedge clk);
        chk(phase == 2'd1 && scl == 1'b0, "R2 start in low", int'(phase), 1);
        if (disturb) begin
            prescale = 16'(p + 3); low_len = 16'(l + 9); high_len = 16'(h + 4);
        end
        count_while(1'b0, nl);
        chk(phase == 2'd2, "R9 high code", int'(phase), 2);
        count_while(1'b1, nh);
        count_while(1'b0, nl2);
        chk(nl == half_exp(p, l), disturb ? "R7 low kept" : "R3 low length", nl, half_exp(p, l));
        chk(nh == half_exp(p, h), disturb ? "R7 high kept" : "R4 high length", nh, half_exp(p, h));
        chk(nl + nh == (p + 1) * (l + h + 2 * dval(p)), "R6 period",
            nl + nh, (p + 1) * (l + h + 2 * dval(p)));
        chk(nl2 == nl, "R6 repeat low", nl2, nl);
        // now in high phase; drop enable
        enable = 1'b0;
        @(negedge clk);
        chk(scl == 1'b1 && phase == 2'd0, "R8 halt to idle", int'(phase), 0);
    endtask

    initial begin
        seed_v = $urandom(17);
        repeat (3) @(negedge clk);
        chk(scl == 1'b1 && phase == 2'd0, "R1 reset idle", int'(phase), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(scl == 1'b1 && phase == 2'd0, "R1 disabled idle", int'(scl), 1);
        // R5 directed: each d branch
        run_case(0, 0, 0, 1'b0);
        run_case(1, 3, 2, 1'b0);
        run_case(2, 1, 4, 1'b0);
        run_case(5, 0, 7, 1'b0);
        // R7 disturbed settings
        run_case(1, 4, 6, 1'b1);
        run_case(3, 2, 0, 1'b1);
        // R8 halt during low phase
        @(negedge clk);
        prescale = 16'd2; low_len = 16'd10; high_len = 16'd10; enable = 1'b1;
        repeat (5) @(negedge clk);
        chk(phase == 2'd1, "R8 low before halt", int'(phase), 1);
        enable = 1'b0;
        @(negedge clk);
        chk(scl == 1'b1 && phase == 2'd0, "R8 halt from low", int'(phase), 0);
        // random cases
        for (int i = 0; i < 10; i++) begin
            run_case(int'($urandom % 8), int'($urandom % 21), int'($urandom % 21), 1'(i % 3 == 0));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule